// File: doc/BRIEF.md
# Frame Statistics Counter Bank

This block holds a bank of event counters for frame statistics. A frame-status source raises a one-cycle pulse on one bit of `evt_inc` for each event it sees (for example, a good unicast frame received), and the matching counter steps by one. Software reaches the bank through a simple register port with byte-lane strobes. Each access takes one cycle of `reg_req`. Read data comes back registered, on the cycle after the request.

A control register sets the counting rules. These are a self-clearing global clear, saturation at all ones instead of wrap-around, zeroing of a counter when its low byte lane is read, and a freeze that stops all event counting. A status register raises one flag per counter when that counter's top bit turns on, which means it has reached half of its range. An enable register picks which flags drive the `irq` output. A flag clears only through a read of its counter that covers byte lane 0.

Top module: `fsc_bank`

## Requirements
- R1: After reset, every counter, the control register, the status register, the enable register, `irq` and `reg_rvalid` are zero.
- R2: Register map, as byte addresses. Counter i is at 0x000 + 4*i. Control is at 0x100. Status is at 0x104, with bit i for counter i. Interrupt enable is at 0x108, with bit i for counter i. A read gives `reg_rvalid` high and `reg_rdata` valid on the cycle after the request. Unused bits and unmapped addresses read as zero. Counters narrower than 32 bits are zero-extended.
- R3: Each `evt_inc[i]` pulse adds one to counter i. When saturation is off, a counter at all ones wraps to zero on the next event.
- R4: With control bit 1 (saturate) set, a counter at all ones stays at all ones on further events.
- R5: A write with `reg_be[0]` high and control bit 0 (global clear) at 1 clears every counter and every status flag on the following cycle. The bit clears itself after one cycle and then reads as zero.
- R6: With control bit 2 (clear-on-read) set, a counter read with `reg_be[0]` high zeroes that counter and returns its value from before the clear. A read with `reg_be[0]` low leaves the counter unchanged.
- R7: When a clearing read and an event hit the same counter in the same cycle, the counter ends at zero and the event is lost.
- R8: With control bit 3 (freeze) set, events change no counter. A clearing read under R6 still zeroes its counter.
- R9: Status bit i is set when an event moves counter i's top bit from 0 to 1. It is not set again while that bit stays 1.
- R10: Status bit i clears on a read of counter i with `reg_be[0]` high, whether or not clear-on-read is set. A read with `reg_be[0]` low leaves the bit set.
- R11: `irq` is high exactly when some status bit and its enable bit are both 1.
- R12: Writes to counter addresses and to the status register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_inc | input | NUM_CNT | One-cycle event pulses, bit i for counter i |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | ADDR_W | Byte address |
| reg_be | input | 4 | Byte-lane strobes, bit 0 for bits 7:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | High on the cycle after a read request |
| irq | output | 1 | Interrupt, the OR of the enabled status flags |

## Verification
The assertions check on every cycle that counters respond correctly to each event. They cover the step by one, the hold in saturation and under freeze, and the zeroing after a global clear or a clearing read. They also check that flags rise on the half-range event and drop on a low-lane read, that the global clear bit goes back to zero, and that a read request is answered one cycle later. Only the bench scenarios can show the things that need several steps. These are the exact address decoding and the returned values, the pre-clear value on a clearing read, and the loss of an event that collides with a clear. They also include the fact that a flag does not rise again while the top bit stays high, the interrupt masking, and the writes that are ignored.

// File: rtl/fsc_pkg.sv
// Package: shared register offsets and control-field layout for the
// frame statistics counter bank. Assumes byte addressing, 32-bit words.
package fsc_pkg;
    localparam int CNT_BASE_OFS = 'h000;
    localparam int CTRL_OFS     = 'h100;
    localparam int STAT_OFS     = 'h104;
    localparam int IEN_OFS      = 'h108;

    // Control fields, MSB first so that bit 0 is the global clear.
    typedef struct packed {
        logic freeze;
        logic clr_on_rd;
        logic sat;
        logic glb_clr;
    } fsc_ctrl_t;
endpackage

// File: rtl/fsc_counter.sv
// Module: one event counter of the bank.
// Applies these rules in order: global clear, clearing read, then a gated
// increment. An increment is blocked by freeze, and also by saturation
// when the counter is at all ones. Reports the increment that turns the
// top bit on. Assumes inc is a one-cycle pulse.
module fsc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             glb_clr,
    input  logic             rd_clr,
    input  logic             freeze,
    input  logic             sat,
    output logic [CNT_W-1:0] cnt,
    output logic             half_evt
);
    localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};

    logic at_max;
    logic step;

    // Decide whether this cycle's event advances the counter.
    always_comb begin
        at_max   = &cnt;
        step     = inc && !freeze && !(sat && at_max);
        half_evt = step && !glb_clr && !rd_clr && (cnt == HALF_M1);
    end

    // Counter state: clears have priority over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (glb_clr || rd_clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r5_glb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        glb_clr |=> (cnt == '0));
    a_r6_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (cnt == '0));
    a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !rd_clr && !glb_clr) |=> $stable(cnt));
    a_r4_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && (&cnt) && !rd_clr && !glb_clr) |=> (&cnt));
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !freeze && !sat && !rd_clr && !glb_clr)
            |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/fsc_ctrl.sv
// Module: control and interrupt-enable registers.
// The global clear bit is stored as a one-cycle pulse. The other control
// bits and the enables hold until rewritten. Assumes the write strobes
// are already qualified by address and byte lane 0.
module fsc_ctrl
    import fsc_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl,
    input  logic               wr_ien,
    input  logic [3:0]         wdata_ctrl,
    input  logic [NUM_CNT-1:0] wdata_ien,
    output fsc_ctrl_t          ctrl,
    output logic [NUM_CNT-1:0] ien
);
    // Control register, with a self-clearing global clear bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            ctrl.glb_clr <= wr_ctrl && wdata_ctrl[0];
            if (wr_ctrl) begin
                ctrl.sat       <= wdata_ctrl[1];
                ctrl.clr_on_rd <= wdata_ctrl[2];
                ctrl.freeze    <= wdata_ctrl[3];
            end
        end
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= '0;
        end else if (wr_ien) begin
            ien <= wdata_ien;
        end
    end

    a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.glb_clr && !wr_ctrl) |=> !ctrl.glb_clr);
endmodule

// File: rtl/fsc_status.sv
// Module: per-counter half-range flags and the interrupt line.
// A flag is set by its counter's half-range event and cleared by a read of
// that counter covering byte lane 0. If both happen in the same cycle the
// set wins, because the read returned a value below half. The global
// clear drops every flag.
module fsc_status #(
    parameter int NUM_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] half_evt,
    input  logic [NUM_CNT-1:0] rd_hit,
    input  logic               glb_clr,
    input  logic [NUM_CNT-1:0] ien,
    output logic [NUM_CNT-1:0] status,
    output logic               irq
);
    // Flag register: global clear, then set, then read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (glb_clr) begin
            status <= '0;
        end else begin
            status <= (status & ~rd_hit) | half_evt;
        end
    end

    // Interrupt: any enabled flag.
    always_comb irq = |(status & ien);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            (half_evt[i] && !glb_clr) |=> status[i]);
        a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit[i] && !half_evt[i]) |=> !status[i]);
    end
endmodule

// File: rtl/fsc_bank.sv
// Module: top of the frame statistics counter bank.
// Decodes the register port, builds one counter per event input, and
// returns read data registered one cycle after the request. Assumes
// NUM_CNT <= 32, CNT_W <= 32, and that the address space fits ADDR_W.
module fsc_bank
    import fsc_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] evt_inc,
    input  logic               reg_req,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [3:0]         reg_be,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               reg_rvalid,
    output logic               irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_OFS);

    fsc_ctrl_t          ctrl;
    logic [NUM_CNT-1:0] ien;
    logic [NUM_CNT-1:0] status;
    logic [NUM_CNT-1:0] cnt_sel;
    logic [NUM_CNT-1:0] rd_hit;
    logic [NUM_CNT-1:0] rd_clr;
    logic [NUM_CNT-1:0] half_evt;
    logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
    logic               rd_req;
    logic               wr_ctrl;
    logic               wr_ien;
    logic [31:0]        rd_nxt;
    logic               unused_wbits;

    assign unused_wbits = ^{reg_wdata, reg_be[3:1]};

    // Access decode: kind of access, and which register it targets.
    always_comb begin
        rd_req  = reg_req && !reg_wr;
        wr_ctrl = reg_req && reg_wr && reg_be[0] && (reg_addr == A_CTRL);
        wr_ien  = reg_req && reg_wr && reg_be[0] && (reg_addr == A_IEN);
        for (int i = 0; i < NUM_CNT; i++) begin
            cnt_sel[i] = (reg_addr == ADDR_W'(CNT_BASE_OFS + 4 * i));
        end
        rd_hit = (rd_req && reg_be[0]) ? cnt_sel : '0;
        rd_clr = ctrl.clr_on_rd ? rd_hit : '0;
    end

    fsc_ctrl #(.NUM_CNT(NUM_CNT)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_ien     (wr_ien),
        .wdata_ctrl (reg_wdata[3:0]),
        .wdata_ien  (reg_wdata[NUM_CNT-1:0]),
        .ctrl       (ctrl),
        .ien        (ien)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        fsc_counter #(.CNT_W(CNT_W)) i_counter (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (evt_inc[i]),
            .glb_clr  (ctrl.glb_clr),
            .rd_clr   (rd_clr[i]),
            .freeze   (ctrl.freeze),
            .sat      (ctrl.sat),
            .cnt      (cnt_arr[i]),
            .half_evt (half_evt[i])
        );
    end

    fsc_status #(.NUM_CNT(NUM_CNT)) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_evt (half_evt),
        .rd_hit   (rd_hit),
        .glb_clr  (ctrl.glb_clr),
        .ien      (ien),
        .status   (status),
        .irq      (irq)
    );

    // Read mux: select the addressed register, zero for unmapped addresses.
    always_comb begin
        rd_nxt = '0;
        if (reg_addr == A_CTRL) begin
            rd_nxt[3:0] = ctrl;
        end else if (reg_addr == A_STAT) begin
            rd_nxt[NUM_CNT-1:0] = status;
        end else if (reg_addr == A_IEN) begin
            rd_nxt[NUM_CNT-1:0] = ien;
        end else begin
            for (int i = 0; i < NUM_CNT; i++) begin
                if (cnt_sel[i]) rd_nxt[CNT_W-1:0] = cnt_arr[i];
            end
        end
    end

    // Read return register: captures the pre-clear value on the clear edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= rd_req;
            if (rd_req) reg_rdata <= rd_nxt;
        end
    end

    a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> reg_rvalid);
    a_r2_rvalid_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !reg_rvalid);
    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

// File: tb/test_fsc_bank.sv
// Directed bench for fsc_bank with 8-bit counters, so that the half-range
// and all-ones boundaries can be reached by pulsing.
module test_fsc_bank;
    localparam int NUM_CNT = 4;
    localparam int CNT_W   = 8;
    localparam int ADDR_W  = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_CNT-1:0] evt_inc = '0;
    logic               reg_req = 1'b0;
    logic               reg_wr = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [3:0]         reg_be = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic               reg_rvalid;
    logic               irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    fsc_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_fsc_bank (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .reg_req(reg_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = 1'b1; reg_addr = ADDR_W'(addr); reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input int addr, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = 1'b0; reg_addr = ADDR_W'(addr); reg_be = be;
        @(negedge clk);
        reg_req = 1'b0;
        d = reg_rdata;
        chk("R2 rvalid", 32'(reg_rvalid), 32'd1);
    endtask

    task automatic pulse(input int idx, input int n);
        @(negedge clk);
        evt_inc[idx] = 1'b1;
        repeat (n) @(negedge clk);
        evt_inc[idx] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 rvalid", 32'(reg_rvalid), 32'd0);
        for (int i = 0; i < NUM_CNT; i++) begin
            rd(4 * i, 4'hF, d); chk("R1 counter", d, 32'd0);
        end
        rd('h100, 4'hF, d); chk("R1 control", d, 32'd0);
        rd('h104, 4'hF, d); chk("R1 status", d, 32'd0);
        rd('h108, 4'hF, d); chk("R1 enable", d, 32'd0);
        rd('h10C, 4'hF, d); chk("R2 unmapped", d, 32'd0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        pulse(0, 5);
        pulse(1, 3);
        rd(0, 4'hF, d); chk("R3 count c0", d, 32'd5);
        rd(4, 4'hF, d); chk("R3 count c1", d, 32'd3);
        rd(0, 4'hF, d); chk("R3 no clear without mode", d, 32'd5);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        pulse(2, 255);
        rd(8, 4'hF, d); chk("R3 at all ones", d, 32'd255);
        rd('h104, 4'hF, d); chk("R10 flag cleared by c2 read", d, 32'd0);
        pulse(2, 1);
        rd(8, 4'hF, d); chk("R3 wrap to zero", d, 32'd0);
    endtask

    task automatic t_half();
        logic [31:0] d;
        pulse(3, 127);
        rd('h104, 4'hF, d); chk("R9 below half", d, 32'd0);
        pulse(3, 1);
        rd('h104, 4'hF, d); chk("R9 half reached", d, 32'h8);
        chk("R11 masked", 32'(irq), 32'd0);
        wr('h108, 4'h1, 32'h8);
        @(negedge clk); chk("R11 enabled", 32'(irq), 32'd1);
        wr('h104, 4'hF, 32'h0);
        rd('h104, 4'hF, d); chk("R12 status write ignored", d, 32'h8);
        rd(12, 4'hE, d); chk("R10 high lanes value", d, 32'd128);
        rd('h104, 4'hF, d); chk("R10 kept on high-lane read", d, 32'h8);
        rd(12, 4'h1, d); chk("R10 low lane value", d, 32'd128);
        rd('h104, 4'hF, d); chk("R10 cleared by low-lane read", d, 32'h0);
        chk("R11 drops", 32'(irq), 32'd0);
        pulse(3, 5);
        rd('h104, 4'hF, d); chk("R9 no re-set while top bit high", d, 32'h0);
        rd(12, 4'hF, d); chk("R3 c3 value", d, 32'd133);
    endtask

    task automatic t_sat();
        logic [31:0] d;
        wr('h100, 4'h1, 32'h2);
        pulse(1, 260);
        rd(4, 4'hF, d); chk("R4 saturated", d, 32'd255);
        pulse(1, 2);
        rd(4, 4'hF, d); chk("R4 stays", d, 32'd255);
        rd('h100, 4'hF, d); chk("R2 control readback", d, 32'h2);
        wr('h100, 4'h1, 32'h0);
    endtask

    task automatic t_glb();
        logic [31:0] d;
        pulse(3, 1);
        wr('h100, 4'h1, 32'h1);
        rd('h100, 4'hF, d); chk("R5 self clear", d, 32'h0);
        for (int i = 0; i < NUM_CNT; i++) begin
            rd(4 * i, 4'hE, d); chk("R5 counter cleared", d, 32'd0);
        end
        rd('h104, 4'hF, d); chk("R5 flags cleared", d, 32'h0);
    endtask

    task automatic t_ror();
        logic [31:0] d;
        wr('h100, 4'h1, 32'h4);
        pulse(0, 7);
        rd(0, 4'h2, d); chk("R6 high lane value", d, 32'd7);
        rd(0, 4'h1, d); chk("R6 pre-clear value", d, 32'd7);
        rd(0, 4'h1, d); chk("R6 cleared", d, 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pulse(0, 3);
        @(negedge clk);
        evt_inc[0] = 1'b1;
        reg_req = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_be = 4'h1;
        @(negedge clk);
        evt_inc[0] = 1'b0; reg_req = 1'b0;
        chk("R7 returned old", reg_rdata, 32'd3);
        rd(0, 4'h1, d); chk("R7 event dropped", d, 32'd0);
        wr('h100, 4'h1, 32'h0);
    endtask

    task automatic t_freeze();
        logic [31:0] d;
        pulse(1, 4);
        wr('h100, 4'h1, 32'h8);
        pulse(1, 10);
        rd(4, 4'h1, d); chk("R8 frozen", d, 32'd4);
        wr('h100, 4'h1, 32'hC);
        rd(4, 4'h1, d); chk("R8 read under freeze", d, 32'd4);
        rd(4, 4'h1, d); chk("R8 clear under freeze", d, 32'd0);
        wr('h100, 4'h1, 32'h0);
    endtask

    task automatic t_wr_ignore();
        logic [31:0] d;
        pulse(2, 9);
        wr(8, 4'hF, 32'h5A);
        rd(8, 4'hF, d); chk("R12 counter write ignored", d, 32'd9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_wrap();
        t_half();
        t_sat();
        t_glb();
        t_ror();
        t_collide();
        t_freeze();
        t_wr_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule